// File: doc/BRIEF.md
# Key-Sequenced Watchdog Reset Unit

This block is a watchdog timer built around a 64-bit up-counter and a 64-bit period. Software arms it through a control register by first setting an enable bit and then writing two 16-bit keys in a fixed order. Once armed, the counter advances on every clock. The unit requests a system reset when the count meets the period, or when software writes a key that breaks the expected order. Software keeps the unit from firing by writing the same two keys again. This clears the counter.

Access is through a flat word-addressed register bus. A write strobe carries an address and 32 bits of data, and read data is returned combinationally for the address currently presented. The reset request is a one-cycle pulse. A sticky status bit remembers that the unit has fired until software writes 1 to it. The watchdog path only responds to keys while a separate mode register selects watchdog operation. The mode register, the count words and the period words are frozen while the unit is armed.

Register map, at byte offsets:
- 0x00: control. Bit 0 is enable, bit 1 is status (write 1 to clear), bits [3:2] read back the state, and bits [31:16] are the key.
- 0x04: mode, in bits [1:0].
- 0x08 and 0x0C: count, low word then high word.
- 0x10 and 0x14: period, low word then high word.

The state encoding is idle=0, primed=1, armed=2, servicing=3. The first key is 0xA5C6 and the second key is 0xDA7E.

Top module: `wdog_keyseq_top`

## Requirements
- R1: After reset, every register reads 0: control, mode, count and period. The reset output is low, and the state field (control bits [3:2]) is 0 (idle).
- R2: A control write is treated as a key write only while the mode field (bits [1:0] at 0x04) holds 2. The mode register accepts writes only in the idle state, and writes in any other state leave it unchanged.
- R3: In idle, a key write with bit 0 = 1 and key 0xA5C6 in bits [31:16] moves the state to primed (1).
- R4: In primed, a key write with bit 0 = 1 and key 0xDA7E moves the state to armed (2). A key write with bit 0 = 0 returns the state to idle (0).
- R5: In idle or primed, a key write with any other key leaves the state unchanged and produces no reset pulse.
- R6: While armed or servicing, the count increases by 1 on every clock. Writes to the count words (0x08/0x0C) and period words (0x10/0x14) are ignored. When not armed, those words are written directly.
- R7: While armed or servicing, if the count equals the period on a clock edge, the reset output is high for the following cycle.
- R8: In armed, key 0xA5C6 moves the state to servicing (3). In servicing, key 0xDA7E clears the count to 0 and returns the state to armed.
- R9: A key write of anything other than 0xA5C6 in armed, or of anything other than 0xDA7E in servicing, raises the reset output in the cycle after the write.
- R10: While armed or servicing, the enable bit stays at 1 even when a control write carries bit 0 = 0.
- R11: The reset output is never high for two consecutive cycles. After a pulse, the state is idle, enable is 0 and the count is 0.
- R12: The status bit (control bit 1) becomes 1 together with each reset pulse and is cleared by a control write with bit 1 = 1. If a pulse and a clear happen on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 5 | Byte address of the register being written or read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| wdog_rst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that bus addresses are word aligned and that the write strobe lasts exactly one cycle with stable address and data. The bench drives every write from a task that raises the strobe at a falling edge for a single cycle, and only uses the six defined offsets. The assertions also assume the mode register is only set to 2 while idle. The stimulus programs the period before arming, and uses periods small enough for expiry to occur inside the run, or large enough that only key errors can fire.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned MODE_OFS = 4;
  localparam int unsigned CNT_OFS  = 8;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned STAT_BIT = 1;
  localparam int unsigned KEY_LSB  = 16;
  localparam logic [1:0]  MODE_WDOG = 2'd2;

  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_PRIMED = 2'd1,
    WD_ARMED  = 2'd2,
    WD_SVC    = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
  import wdk_pkg::*;
#(
  parameter int unsigned KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_A = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_B = 16'hDA7E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             key_wr,
  input  logic             en_bit,
  input  logic [KEY_W-1:0] key,
  input  logic             expire,
  output wd_state_e        state,
  output logic             en,
  output logic             armed,
  output logic             fire,
  output logic             svc_clr,
  output logic             bite
);

  wd_state_e state_q, state_d;
  logic      en_q, en_d;
  logic      bite_q;
  logic      bad_key;

  assign armed = (state_q == WD_ARMED) || (state_q == WD_SVC);

  always_comb begin
    bad_key = 1'b0;
    if (key_wr) begin
      if (state_q == WD_ARMED && key != KEY_A) bad_key = 1'b1;
      if (state_q == WD_SVC   && key != KEY_B) bad_key = 1'b1;
    end
  end

  assign fire    = expire || bad_key;
  assign svc_clr = key_wr && (state_q == WD_SVC) && (key == KEY_B) && !expire;

  always_comb begin
    state_d = state_q;
    if (fire) begin
      state_d = WD_IDLE;
    end else if (key_wr) begin
      unique case (state_q)
        WD_IDLE:   if (en_bit && key == KEY_A) state_d = WD_PRIMED;
        WD_PRIMED: begin
          if (!en_bit)           state_d = WD_IDLE;
          else if (key == KEY_B) state_d = WD_ARMED;
        end
        WD_ARMED:  state_d = WD_SVC;
        WD_SVC:    state_d = WD_ARMED;
        default:   state_d = WD_IDLE;
      endcase
    end
  end

  always_comb begin
    en_d = en_q;
    if (fire)                  en_d = 1'b0;
    else if (ctrl_wr && !armed) en_d = en_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      en_q    <= 1'b0;
      bite_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      bite_q  <= fire;
    end
  end

  assign state = state_q;
  assign en    = en_q;
  assign bite  = bite_q;

  // R11
  bite_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bite |=> !bite);

  // R11
  bite_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bite |-> (state_q == WD_IDLE) && !en_q);

  // R9
  bad_key_bite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && state_q == WD_ARMED && key != KEY_A) |=> bite);

  // R10
  en_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fire) |=> en);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_IDLE) |=> !bite);

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NWORDS = CNT_W / WORD_W,
  localparam int unsigned SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              clear,
  input  logic              cnt_wr,
  input  logic              prd_wr,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  prd,
  output logic              expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d, prd_q, prd_d;
  logic [CNT_W-1:0] cnt_wv, prd_wv;
  logic             cnt_ce, prd_ce;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    assign cnt_wv[g*WORD_W +: WORD_W] =
      (cnt_wr && wsel == SEL_W'(g)) ? wdata : cnt_q[g*WORD_W +: WORD_W];
    assign prd_wv[g*WORD_W +: WORD_W] =
      (prd_wr && wsel == SEL_W'(g)) ? wdata : prd_q[g*WORD_W +: WORD_W];
  end

  assign expire = armed && (cnt_q == prd_q);

  always_comb begin
    cnt_ce = clear || armed || cnt_wr;
    if (clear)      cnt_d = '0;
    else if (armed) cnt_d = cnt_q + CNT_W'(1);
    else            cnt_d = cnt_wv;
    prd_ce = prd_wr && !armed;
    prd_d  = prd_wv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      prd_q <= '0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      if (prd_ce) prd_q <= prd_d;
    end
  end

  assign cnt = cnt_q;
  assign prd = prd_q;

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clear) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R6
  period_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(prd_q));

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_keyseq_top.sv
module wdog_keyseq_top
  import wdk_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned KEY_W  = 16,
  parameter logic [KEY_W-1:0] KEY_A = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_B = 16'hDA7E,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              wdog_rst_o
);

  localparam int unsigned NWORDS = CNT_W / BUS_W;
  localparam int unsigned SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_OFS);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_OFS);
  localparam logic [ADDR_W-1:0] A_PRD  = A_CNT + ADDR_W'(4 * NWORDS);
  localparam logic [ADDR_W-1:0] A_END  = A_PRD + ADDR_W'(4 * NWORDS);

  wd_state_e        state;
  logic             en, armed, fire, svc_clr, bite, expire;
  logic             ctrl_wr, key_wr, mode_wr, cnt_wr, prd_wr;
  logic             in_cnt, in_prd;
  logic [ADDR_W-1:0] cnt_off, prd_off;
  logic [SEL_W-1:0] cnt_idx, prd_idx, wsel;
  logic [CNT_W-1:0] cnt, prd;
  logic [1:0]       mode_q, mode_d;
  logic             mode_ce;
  logic             stat_q, stat_d;

  // address decode
  always_comb begin
    cnt_off = addr - A_CNT;
    prd_off = addr - A_PRD;
    in_cnt  = (addr >= A_CNT) && (addr < A_PRD) && (addr[1:0] == 2'b00);
    in_prd  = (addr >= A_PRD) && (addr < A_END) && (addr[1:0] == 2'b00);
    cnt_idx = SEL_W'(cnt_off >> 2);
    prd_idx = SEL_W'(prd_off >> 2);
    wsel    = in_cnt ? cnt_idx : prd_idx;
    ctrl_wr = wr_en && (addr == A_CTRL);
    mode_wr = wr_en && (addr == A_MODE);
    cnt_wr  = wr_en && in_cnt;
    prd_wr  = wr_en && in_prd;
    key_wr  = ctrl_wr && (mode_q == MODE_WDOG);
  end

  wdk_keyfsm #(
    .KEY_W (KEY_W),
    .KEY_A (KEY_A),
    .KEY_B (KEY_B)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .key_wr  (key_wr),
    .en_bit  (wdata[EN_BIT]),
    .key     (wdata[KEY_LSB +: KEY_W]),
    .expire  (expire),
    .state   (state),
    .en      (en),
    .armed   (armed),
    .fire    (fire),
    .svc_clr (svc_clr),
    .bite    (bite)
  );

  wdk_counter #(
    .CNT_W  (CNT_W),
    .WORD_W (BUS_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (armed),
    .clear  (fire || svc_clr),
    .cnt_wr (cnt_wr),
    .prd_wr (prd_wr),
    .wsel   (wsel),
    .wdata  (wdata),
    .cnt    (cnt),
    .prd    (prd),
    .expire (expire)
  );

  // mode and status next state
  always_comb begin
    mode_ce = mode_wr && (state == WD_IDLE);
    mode_d  = wdata[1:0];
    stat_d  = stat_q;
    if (fire)                          stat_d = 1'b1;
    else if (ctrl_wr && wdata[STAT_BIT]) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      stat_q <= 1'b0;
    end else begin
      if (mode_ce) mode_q <= mode_d;
      stat_q <= stat_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) begin
      rdata[EN_BIT]   = en;
      rdata[STAT_BIT] = stat_q;
      rdata[3:2]      = state;
    end else if (addr == A_MODE) begin
      rdata[1:0] = mode_q;
    end else if (in_cnt) begin
      rdata = cnt[cnt_idx*BUS_W +: BUS_W];
    end else if (in_prd) begin
      rdata = prd[prd_idx*BUS_W +: BUS_W];
    end
  end

  assign wdog_rst_o = bite;

  // R7
  expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> wdog_rst_o);

  // R12
  status_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> stat_q);

  // R2
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != WD_IDLE) |=> $stable(mode_q));

  // R8
  service_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_clr |=> (cnt == '0) && (state == WD_ARMED));

endmodule

// File: tb/wdog_keyseq_top_test.sv
module wdog_keyseq_top_test;
  localparam logic [15:0] KA = 16'hA5C6;
  localparam logic [15:0] KB = 16'hDA7E;

  logic        clk, rst_n, wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        wdog_rst_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          m_state;
  logic        m_en, m_stat, m_rst;
  logic [1:0]  m_mode;
  logic [63:0] m_cnt, m_prd;

  logic        last_rst;

  wdog_keyseq_top uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .wdog_rst_o (wdog_rst_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] ctl(input logic [15:0] k, input logic e, input logic c);
    return {k, 14'd0, c, e};
  endfunction

  function automatic logic [31:0] model_rd(input logic [4:0] a);
    case (a)
      5'h00: return {28'd0, 2'(m_state), m_stat, m_en};
      5'h04: return {30'd0, m_mode};
      5'h08: return m_cnt[31:0];
      5'h0C: return m_cnt[63:32];
      5'h10: return m_prd[31:0];
      5'h14: return m_prd[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00: return "R3";
      5'h04: return "R2";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference, stepped on every rising edge, compared shortly after
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_en = 0; m_stat = 0; m_rst = 0; m_mode = 0; m_cnt = 0; m_prd = 0;
    end else begin
      logic [15:0] k;
      bit ctrlw, keyw, armed, hit, bad;
      int nxt;
      k     = wdata[31:16];
      ctrlw = wr_en && addr == 5'h00;
      keyw  = ctrlw && m_mode == 2'd2;
      armed = m_state >= 2;
      hit   = armed && m_cnt == m_prd;
      bad   = keyw && ((m_state == 2 && k != KA) || (m_state == 3 && k != KB));
      m_rst = hit || bad;
      if (m_rst) begin
        m_state = 0; m_en = 0; m_cnt = 0; m_stat = 1;
      end else begin
        nxt = m_state;
        if (ctrlw && wdata[1]) m_stat = 0;
        if (wr_en && addr == 5'h04 && m_state == 0) m_mode = wdata[1:0];
        if (armed) begin
          if (keyw && m_state == 3 && k == KB) m_cnt = 0;
          else m_cnt = m_cnt + 1;
        end else if (wr_en) begin
          if (addr == 5'h08) m_cnt[31:0]  = wdata;
          if (addr == 5'h0C) m_cnt[63:32] = wdata;
          if (addr == 5'h10) m_prd[31:0]  = wdata;
          if (addr == 5'h14) m_prd[63:32] = wdata;
        end
        if (ctrlw && !armed) m_en = wdata[0];
        if (keyw) begin
          case (m_state)
            0: if (wdata[0] && k == KA) nxt = 1;
            1: if (!wdata[0]) nxt = 0; else if (k == KB) nxt = 2;
            2: nxt = 3;
            default: nxt = 2;
          endcase
        end
        m_state = nxt;
      end
      #1;
      chk("R7", {31'd0, wdog_rst_o}, {31'd0, m_rst});
      chk(tag_of(addr), rdata, model_rd(addr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    last_rst = wdog_rst_o;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a0, b0;
    int pulses;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; last_rst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(5'(i * 4), v);
      chk("R1", v, 32'd0);
    end
    chk("R1", {31'd0, wdog_rst_o}, 32'd0);

    // R6 direct writes when not armed
    wr(5'h10, 32'd200);
    wr(5'h08, 32'd7);
    rd(5'h08, v); chk("R6", v, 32'd7);

    // R2 key ignored while mode is not watchdog
    wr(5'h00, ctl(KA, 1'b1, 1'b0));
    rd(5'h00, v); chk("R2", v, 32'h1);
    wr(5'h04, 32'd2);
    rd(5'h04, v); chk("R2", v, 32'd2);

    // R5 wrong key in idle
    wr(5'h00, ctl(16'h1234, 1'b1, 1'b0));
    chk("R5", {31'd0, last_rst}, 32'd0);
    rd(5'h00, v); chk("R5", v, 32'h1);

    // R3 first key
    wr(5'h00, ctl(KA, 1'b1, 1'b0));
    rd(5'h00, v); chk("R3", v, 32'h5);

    // R5 wrong key in primed
    wr(5'h00, ctl(16'h5555, 1'b1, 1'b0));
    chk("R5", {31'd0, last_rst}, 32'd0);
    rd(5'h00, v); chk("R5", v, 32'h5);

    // R4 enable dropped returns to idle
    wr(5'h00, ctl(KB, 1'b0, 1'b0));
    rd(5'h00, v); chk("R4", v, 32'h0);

    // R4 full arm
    wr(5'h00, ctl(KA, 1'b1, 1'b0));
    wr(5'h00, ctl(KB, 1'b1, 1'b0));
    rd(5'h00, v); chk("R4", v, 32'h9);

    // R6 counting
    addr = 5'h08;
    @(negedge clk); #1 a0 = rdata;
    repeat (10) @(negedge clk);
    #1 b0 = rdata;
    chk("R6", b0 - a0, 32'd10);

    // R6 writes ignored while armed
    wr(5'h08, 32'd0);
    rd(5'h08, v); chk("R6", {31'd0, v > 32'd10}, 32'd1);
    wr(5'h10, 32'd5);
    rd(5'h10, v); chk("R6", v, 32'd200);
    // R2 mode frozen while armed
    wr(5'h04, 32'd0);
    rd(5'h04, v); chk("R2", v, 32'd2);

    // R10 enable locked, R8 service
    wr(5'h00, ctl(KA, 1'b0, 1'b0));
    rd(5'h00, v); chk("R10", v, 32'hD);
    wr(5'h00, ctl(KB, 1'b1, 1'b0));
    rd(5'h00, v); chk("R8", v, 32'h9);
    rd(5'h08, v); chk("R8", {31'd0, v < 32'd5}, 32'd1);

    // R7 / R11 expiry produces exactly one pulse
    pulses = 0;
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      if (wdog_rst_o) pulses++;
    end
    chk("R11", 32'(pulses), 32'd1);
    rd(5'h00, v); chk("R12", v, 32'h2);
    rd(5'h08, v); chk("R11", v, 32'd0);

    // R12 clear status
    wr(5'h00, ctl(16'h0000, 1'b0, 1'b1));
    rd(5'h00, v); chk("R12", v, 32'h0);

    // R9 wrong key while armed
    wr(5'h14, 32'd1);
    wr(5'h00, ctl(KA, 1'b1, 1'b0));
    wr(5'h00, ctl(KB, 1'b1, 1'b0));
    wr(5'h00, ctl(16'h0000, 1'b1, 1'b0));
    chk("R9", {31'd0, last_rst}, 32'd1);
    rd(5'h00, v); chk("R9", v, 32'h2);

    // R9 wrong key while servicing
    wr(5'h00, ctl(16'h0000, 1'b0, 1'b1));
    wr(5'h00, ctl(KA, 1'b1, 1'b0));
    wr(5'h00, ctl(KB, 1'b1, 1'b0));
    wr(5'h00, ctl(KA, 1'b1, 1'b0));
    rd(5'h00, v); chk("R8", v, 32'hD);
    wr(5'h00, ctl(KA, 1'b1, 1'b0));
    chk("R9", {31'd0, last_rst}, 32'd1);

    // R12 pulse wins over clear on the same edge
    wr(5'h00, ctl(16'h0000, 1'b0, 1'b1));
    wr(5'h00, ctl(KA, 1'b1, 1'b0));
    wr(5'h00, ctl(KB, 1'b1, 1'b0));
    wr(5'h00, ctl(16'hBEEF, 1'b1, 1'b1));
    chk("R9", {31'd0, last_rst}, 32'd1);
    rd(5'h00, v); chk("R12", v, 32'h2);

    // R7 period equal to count at arming fires on the next edge
    wr(5'h00, ctl(16'h0000, 1'b0, 1'b1));
    wr(5'h14, 32'd0);
    wr(5'h10, 32'd0);
    wr(5'h08, 32'd0);
    wr(5'h00, ctl(KA, 1'b1, 1'b0));
    wr(5'h00, ctl(KB, 1'b1, 1'b0));
    chk("R7", {31'd0, last_rst}, 32'd0);
    @(posedge clk); #1;
    chk("R7", {31'd0, wdog_rst_o}, 32'd1);
    @(posedge clk); #1;
    chk("R11", {31'd0, wdog_rst_o}, 32'd0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule